// File: doc/BRIEF.md
# Banked program counter controller

This block keeps the 12-bit fetch address of a small 8-bit microcontroller whose program space is divided into two 2K halves selected by address bit 11. The instruction sequencer drives it with an increment strobe, a jump/call load that carries only an 11-bit target, and a return load that carries a full 12-bit address popped from the stack. A bank flag, written by software, supplies bit 11 for jumps and calls. Linear execution never crosses from one half into the other.

The block also injects interrupt calls. An external or timer request is latched. When no jump or return is in progress, the block pushes the full current address through a push strobe and moves the fetch address to the vector for that source. From that point until the interrupt return, an in-service indicator is set. While it is set, jumps and calls ignore the software bank flag and use bank 0. The stack memory, instruction decoding and the external bus are outside this block.

Top module: `bank_pc_ctrl`

## Requirements
- R1: After reset, `pc_o` is 000h, `in_service_o` is 0, `push_o` is 0, the bank flag is 0 and no request is pending.
- R2: An increment adds one to bits 10:0 with wrap-around and leaves bit 11 unchanged. So 7FFh becomes 000h and FFFh becomes 800h.
- R3: A jump loads `pc_o` with {bank, `jump_tgt_i`}. The bank flag takes `bank_val_i` on a cycle with `bank_wr_i` = 1, and that value is first used by a jump in the following cycle.
- R4: A return loads all 12 bits of `ret_addr_i`. When `ret_irq_i` = 1 in that cycle, it also clears `in_service_o` on the same edge.
- R5: An accepted request injects a call. `irq_timer_i` = 0 selects the external source, with vector 003h. `irq_timer_i` = 1 selects the timer source, with vector 007h. In the decision cycle, `push_o` = 1 and `push_addr_o` equals the current `pc_o`. After the next edge, `pc_o` holds the vector and `in_service_o` = 1.
- R6: When a request is pending in a cycle that also has a jump or a return, the jump or return is applied first and injection waits one cycle. The pushed address is then that jump's full target, including bit 11. The injected call gives exactly 003h or 007h from either bank.
- R7: While `in_service_o` = 1, a jump loads bit 11 as 0 whatever the bank flag holds. The bank flag keeps its value and applies again to jumps after the interrupt return.
- R8: No request is accepted while `in_service_o` = 1. Requests that arrive then stay pending and are injected after the interrupt return. When both sources are pending, the external one is taken first.
- R9: The order of precedence in a cycle is return, then jump, then injection, then increment. In a cycle with none of these, `pc_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_i | input | 1 | Linear increment strobe |
| jump_i | input | 1 | Jump/call load strobe |
| jump_tgt_i | input | 11 | Jump/call target bits 10:0 |
| ret_i | input | 1 | Return load strobe |
| ret_irq_i | input | 1 | Qualifies a return as an interrupt return |
| ret_addr_i | input | 12 | Full return address |
| bank_wr_i | input | 1 | Bank flag write strobe |
| bank_val_i | input | 1 | Value written to the bank flag |
| irq_req_i | input | 1 | Interrupt request pulse |
| irq_timer_i | input | 1 | Request source: 0 external, 1 timer |
| pc_o | output | 12 | Current fetch address |
| in_service_o | output | 1 | Interrupt service routine active |
| push_o | output | 1 | Push strobe for the injected call |
| push_addr_o | output | 12 | Address to push |

## Verification
The risky overlap is a pending interrupt meeting a jump into bank 1 in the same cycle. Getting it wrong would either lose bit 11 of the target or corrupt the vector. The bench provokes this with a directed case that raises a request one cycle ahead of a jump to a bank-1 target. It then judges the pushed address, the vector and the in-service flag against a bench model. Random runs also mix requests with jumps, returns, bank writes and increments, and each cycle is compared with that model.

// File: rtl/bank_pc_ctrl.sv
module bank_pc_ctrl #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] EXT_VEC = 3,
  parameter logic [ADDR_W-1:0] TMR_VEC = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_i,
  input  logic              jump_i,
  input  logic [ADDR_W-2:0] jump_tgt_i,
  input  logic              ret_i,
  input  logic              ret_irq_i,
  input  logic [ADDR_W-1:0] ret_addr_i,
  input  logic              bank_wr_i,
  input  logic              bank_val_i,
  input  logic              irq_req_i,
  input  logic              irq_timer_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              in_service_o,
  output logic              push_o,
  output logic [ADDR_W-1:0] push_addr_o
);
  localparam int LOW_W = ADDR_W - 1;

  logic [ADDR_W-1:0] pc_q;
  logic              bank_q, isr_q, pend_ext_q, pend_tmr_q;
  logic              take, take_ext;

  assign take     = (pend_ext_q | pend_tmr_q) & ~isr_q & ~ret_i & ~jump_i;
  assign take_ext = pend_ext_q;

  assign pc_o         = pc_q;
  assign in_service_o = isr_q;
  assign push_o       = take;
  assign push_addr_o  = pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (ret_i) begin
      pc_q <= ret_addr_i;
    end else if (jump_i) begin
      pc_q <= {bank_q & ~isr_q, jump_tgt_i};
    end else if (take) begin
      pc_q <= take_ext ? EXT_VEC : TMR_VEC;
    end else if (inc_i) begin
      pc_q <= {pc_q[ADDR_W-1], pc_q[LOW_W-1:0] + {{(LOW_W-1){1'b0}}, 1'b1}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= 1'b0;
      bank_q <= 1'b0;
    end else begin
      if (ret_i && ret_irq_i) isr_q <= 1'b0;
      else if (take)          isr_q <= 1'b1;
      if (bank_wr_i) bank_q <= bank_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_ext_q <= 1'b0;
      pend_tmr_q <= 1'b0;
    end else begin
      pend_ext_q <= (pend_ext_q & ~(take & take_ext)) | (irq_req_i & ~irq_timer_i);
      pend_tmr_q <= (pend_tmr_q & ~(take & ~take_ext)) | (irq_req_i & irq_timer_i);
    end
  end

  // R2
  inc_keeps_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !jump_i && !ret_i && !take) |=>
      (pc_o[ADDR_W-1] == $past(pc_o[ADDR_W-1]) &&
       pc_o[LOW_W-1:0] == $past(pc_o[LOW_W-1:0]) + 1'b1));

  // R5
  vector_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> ((pc_o == EXT_VEC || pc_o == TMR_VEC) && in_service_o));

  // R7
  isr_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service_o && jump_i && !ret_i) |=> !pc_o[ADDR_W-1]);

  // R8
  no_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_service_o |-> !push_o);

  // R4
  reti_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && ret_irq_i) |=> (!in_service_o && pc_o == $past(ret_addr_i)));
endmodule

// File: tb/bank_pc_ctrl_tb.sv
`timescale 1ns/100ps
module bank_pc_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic inc, jmp, ret, reti, bwr, bval, irq, tmr;
  logic [10:0] tgt;
  logic [11:0] raddr;
  logic [11:0] pc_o, push_addr_o;
  logic in_service_o, push_o;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [11:0] m_pc;
  logic m_bank, m_isr, m_pe, m_pt;

  always #2.5 clk = ~clk;

  bank_pc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .inc_i(inc), .jump_i(jmp), .jump_tgt_i(tgt),
    .ret_i(ret), .ret_irq_i(reti), .ret_addr_i(raddr), .bank_wr_i(bwr),
    .bank_val_i(bval), .irq_req_i(irq), .irq_timer_i(tmr), .pc_o(pc_o),
    .in_service_o(in_service_o), .push_o(push_o), .push_addr_o(push_addr_o));

  task automatic chk(string tag, logic [11:0] got, logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %03h expected %03h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic m_take(logic r, logic j);
    return (m_pe | m_pt) & ~m_isr & ~r & ~j;
  endfunction

  function automatic logic [11:0] m_next_pc(logic tk);
    if (ret) return raddr;
    if (jmp) return {m_bank & ~m_isr, tgt};
    if (tk)  return m_pe ? 12'h003 : 12'h007;
    if (inc) return {m_pc[11], m_pc[10:0] + 11'd1};
    return m_pc;
  endfunction

  task automatic idle();
    inc = 0; jmp = 0; ret = 0; reti = 0; bwr = 0; bval = 0; irq = 0; tmr = 0;
    tgt = '0; raddr = '0;
  endtask

  // inputs already set (after a negedge); checks push, clocks, checks state
  task automatic step(string tag);
    logic tk, nisr, npe, npt, nbank;
    logic [11:0] npc;
    #1;
    tk = m_take(ret, jmp);
    chk({tag, " push"}, {11'd0, push_o}, {11'd0, tk});
    if (tk) chk({tag, " push_addr"}, push_addr_o, m_pc);
    npc   = m_next_pc(tk);
    nisr  = (ret && reti) ? 1'b0 : (tk ? 1'b1 : m_isr);
    npe   = (m_pe & ~(tk & m_pe)) | (irq & ~tmr);
    npt   = (m_pt & ~(tk & ~m_pe)) | (irq & tmr);
    nbank = bwr ? bval : m_bank;
    @(posedge clk); #1;
    m_pc = npc; m_isr = nisr; m_pe = npe; m_pt = npt; m_bank = nbank;
    chk({tag, " pc"}, pc_o, m_pc);
    chk({tag, " isr"}, {11'd0, in_service_o}, {11'd0, m_isr});
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    m_pc = 0; m_bank = 0; m_isr = 0; m_pe = 0; m_pt = 0;
    #12; @(negedge clk);
    // R1 reset state
    chk("R1 pc", pc_o, 12'h000);
    chk("R1 isr", {11'd0, in_service_o}, 12'd0);
    chk("R1 push", {11'd0, push_o}, 12'd0);
    rst_n = 1;
    @(negedge clk);
    step("R9 idle hold");

    // R2 wrap at 07FF in bank 0
    jmp = 1; tgt = 11'h7FF; step("R3 jump bank0");
    inc = 1; step("R2 wrap 7FF");
    // R3 bank flag timing: write and jump same cycle uses old flag
    bwr = 1; bval = 1; jmp = 1; tgt = 11'h7FF; step("R3 old bank");
    jmp = 1; tgt = 11'h7FF; step("R3 new bank");
    inc = 1; step("R2 wrap FFF");
    chk("R2 bank1 wrap", pc_o, 12'h800);

    // R6 request pending while jump to bank 1 executes
    irq = 1; tmr = 0; step("R6 latch");
    jmp = 1; tgt = 11'h123; step("R6 jump first");
    step("R6 inject");
    chk("R6 vector", pc_o, 12'h003);

    // R7 bank switch attempt inside service routine
    bwr = 1; bval = 1; step("R7 bank write");
    jmp = 1; tgt = 11'h456; step("R7 jump bank0");
    chk("R7 bit11", {11'd0, pc_o[11]}, 12'd0);
    // R8 timer request while in service is held
    irq = 1; tmr = 1; step("R8 held");
    inc = 1; step("R8 no inject");
    ret = 1; reti = 1; raddr = 12'h923; step("R4 reti");
    step("R8 deferred timer");
    chk("R5 timer vector", pc_o, 12'h007);
    ret = 1; reti = 1; raddr = 12'hA00; step("R4 reti 2");
    jmp = 1; tgt = 11'h010; step("R7 bank restored");
    chk("R7 bank1 again", pc_o, 12'h810);

    // R8 both pending: external first
    irq = 1; tmr = 1; inc = 1; step("R9 inc over nothing");
    irq = 1; tmr = 0; ret = 1; raddr = 12'hFFF; step("R9 ret priority");
    step("R8 ext first");
    ret = 1; reti = 1; raddr = 12'h555; step("R4 reti 3");
    step("R8 timer second");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom(32'd1234 + i) % 100;
      inc  = (r % 3) != 0;
      jmp  = ($urandom % 8) == 0;
      tgt  = 11'($urandom);
      ret  = ($urandom % 10) == 0;
      reti = $urandom % 2;
      raddr = 12'($urandom);
      bwr  = ($urandom % 12) == 0;
      bval = $urandom % 2;
      irq  = ($urandom % 20) == 0;
      tmr  = $urandom % 2;
      step("R9 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule